// File: doc/BRIEF.md
# Multi-Agent Exclusive Access Monitor

This block sits in front of a shared memory and settles exclusive access for several requesting agents. Each agent has a reservation slot of its own. The slot holds a granule-aligned block tag and an Open/Exclusive flag. Every cycle the block sees at most one request. A request carries the agent number, an operation code and a byte address.

A load-exclusive marks the granule that holds the address and sets that agent to Exclusive. A store-exclusive passes only when the agent is still Exclusive on that same granule. When it passes, the block raises the memory write enable. Any write, whether a plain store or a passing store-exclusive, removes the reservations that other agents hold on the written granule. This makes a contested store-exclusive fail, so competing agents see a conflict instead of losing an update.

Pass/fail, write enable and the done strobe are combinational from the current request. Slot state changes at the next rising clock edge.

Top module: `excl_mon`

## Requirements
- R1: After reset every agent is Open. A store-exclusive issued before any load-exclusive fails with status 1 and no write.
- R2: Agents keep independent reservations. Agents that have marked different granules can each pass a store-exclusive in turn.
- R3: A load-exclusive (op code 0) marks the granule `addr[ADDR_W-1:log2(GRANULE_WORDS*WORD_BYTES)]`. With the defaults this is 64-byte blocks. A store-exclusive anywhere in that block may pass. An address in the next block fails.
- R4: A store-exclusive (op code 1) raises `stx_done`. It passes only when the agent is Exclusive and the address matches its marked granule. On a pass, `mem_wr_en` is 1 and `stx_fail` is 0. Otherwise `mem_wr_en` is 0 and `stx_fail` is 1.
- R5: A passing store-exclusive moves every other agent that has marked the written granule to Open.
- R6: A store-exclusive returns the issuing agent to Open, whether it passes or fails.
- R7: A plain store (op code 2) always raises `mem_wr_en`, never raises `stx_done`, and moves other agents with a matching mark to Open.
- R8: A clear-exclusive (op code 3) moves only the issuing agent to Open and does not write.
- R9: A plain store by an agent to its own marked granule leaves its own reservation in place.
- R10: A failed store-exclusive does not disturb any other agent's reservation.
- R11: With `req_valid` low, all outputs are 0 and no reservation changes.
- R12: `GRANULE_WORDS` must be a power of two from 4 to 512. Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_agent | input | AGT_W | Issuing agent number |
| req_op | input | 2 | 0 load-excl, 1 store-excl, 2 store, 3 clear-excl |
| req_addr | input | ADDR_W | Byte address |
| mem_wr_en | output | 1 | Memory write allowed this cycle |
| stx_done | output | 1 | A store-exclusive was answered |
| stx_fail | output | 1 | Store-exclusive status: 1 fail, 0 pass |

## Verification
Two things can happen in the same request. The issuing agent's store-exclusive is judged against its own slot, and that same write clears every other slot that matches. The bench brings this about by having two agents mark one granule, then letting one of them store-exclusive. The write enable and pass status are checked in that cycle. The clearing is judged one request later, when the second agent's store-exclusive to the same granule must fail. The mirror case, a failed store-exclusive sharing a granule with a live reservation, is judged the same way: the survivor must still pass.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
   typedef enum logic [1:0] {
      OP_LDX  = 2'd0,
      OP_STX  = 2'd1,
      OP_ST   = 2'd2,
      OP_CLRX = 2'd3
   } excl_op_e;
endpackage

// File: rtl/excl_mon_slot.sv
module excl_mon_slot #(
   parameter int TAG_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             clr_self_i,
   input  logic             snoop_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic             excl_o,
   output logic             match_o
);
   logic [TAG_W-1:0] tag_q;
   logic             excl_q;

   assign match_o = (tag_q == tag_i);
   assign excl_o  = excl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         excl_q <= 1'b0;
         tag_q  <= '0;
      end else if (set_i) begin
         excl_q <= 1'b1;
         tag_q  <= tag_i;
      end else if (clr_self_i || (snoop_i && match_o)) begin
         excl_q <= 1'b0;
      end
   end

   // R3: a load-exclusive leaves the slot Exclusive
   a_r3_mark_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> excl_o);
   // R5/R7: another agent's write to the marked granule reopens this slot
   a_r5_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_i && match_o && !set_i) |=> !excl_o);
endmodule

// File: rtl/excl_mon_decode.sv
module excl_mon_decode
   import excl_mon_pkg::*;
#(
   parameter int N_AGENTS = 4,
   parameter int AGT_W    = 2
) (
   input  logic                req_valid,
   input  excl_op_e            req_op,
   input  logic [AGT_W-1:0]    req_agent,
   input  logic [N_AGENTS-1:0] excl_vec,
   input  logic [N_AGENTS-1:0] match_vec,
   output logic [N_AGENTS-1:0] set_vec,
   output logic [N_AGENTS-1:0] clr_vec,
   output logic [N_AGENTS-1:0] snoop_vec,
   output logic                mem_wr_en,
   output logic                stx_done,
   output logic                stx_fail
);
   logic is_ldx, is_stx, is_st, is_clr, own_hit, write;

   always_comb begin
      is_ldx    = req_valid && (req_op == OP_LDX);
      is_stx    = req_valid && (req_op == OP_STX);
      is_st     = req_valid && (req_op == OP_ST);
      is_clr    = req_valid && (req_op == OP_CLRX);
      own_hit   = excl_vec[req_agent] && match_vec[req_agent];
      write     = is_st || (is_stx && own_hit);
      mem_wr_en = write;
      stx_done  = is_stx;
      stx_fail  = is_stx && !own_hit;
   end

   for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
      logic sel;
      assign sel          = (req_agent == AGT_W'(i));
      assign set_vec[i]   = is_ldx && sel;
      assign clr_vec[i]   = (is_stx || is_clr) && sel;
      assign snoop_vec[i] = write && !sel;
   end
endmodule

// File: rtl/excl_mon.sv
module excl_mon
   import excl_mon_pkg::*;
#(
   parameter int N_AGENTS      = 4,
   parameter int ADDR_W        = 32,
   parameter int GRANULE_WORDS = 16,
   parameter int WORD_BYTES    = 4,
   localparam int AGT_W        = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1,
   localparam int GRAN_BYTES   = GRANULE_WORDS * WORD_BYTES,
   localparam int OFS_W        = $clog2(GRAN_BYTES),
   localparam int TAG_W        = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [AGT_W-1:0]  req_agent,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              mem_wr_en,
   output logic              stx_done,
   output logic              stx_fail
);
   // R12: elaboration-time parameter checks
   if (GRANULE_WORDS < 4 || GRANULE_WORDS > 512 ||
       (GRANULE_WORDS & (GRANULE_WORDS - 1)) != 0) begin : g_bad_granule
      $error("excl_mon: GRANULE_WORDS must be a power of two in 4..512");
   end
   if (N_AGENTS < 2) begin : g_bad_agents
      $error("excl_mon: N_AGENTS must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("excl_mon: ADDR_W too small for granule");
   end

   logic [TAG_W-1:0]    tag;
   logic [N_AGENTS-1:0] excl_vec, match_vec, set_vec, clr_vec, snoop_vec;

   assign tag = req_addr[ADDR_W-1:OFS_W];

   excl_mon_decode #(.N_AGENTS(N_AGENTS), .AGT_W(AGT_W)) u_decode (
      .req_valid (req_valid),
      .req_op    (excl_op_e'(req_op)),
      .req_agent (req_agent),
      .excl_vec  (excl_vec),
      .match_vec (match_vec),
      .set_vec   (set_vec),
      .clr_vec   (clr_vec),
      .snoop_vec (snoop_vec),
      .mem_wr_en (mem_wr_en),
      .stx_done  (stx_done),
      .stx_fail  (stx_fail)
   );

   for (genvar i = 0; i < N_AGENTS; i++) begin : g_slot
      excl_mon_slot #(.TAG_W(TAG_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_i      (set_vec[i]),
         .clr_self_i (clr_vec[i]),
         .snoop_i    (snoop_vec[i]),
         .tag_i      (tag),
         .excl_o     (excl_vec[i]),
         .match_o    (match_vec[i])
      );
   end

   // R4: an agent that is not Exclusive can never pass or write
   a_r4_open_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'd1 && !excl_vec[req_agent]) |-> (stx_fail && !mem_wr_en));
   // R6: after any store-exclusive the issuer is Open
   a_r6_stx_reopens: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'd1) |=> !excl_vec[$past(req_agent)]);
   // R11: an idle cycle produces no write and no status
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!mem_wr_en && !stx_done && !stx_fail));
   // R11: an idle cycle leaves the Open/Exclusive flags untouched
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(excl_vec));
endmodule

// File: tb/excl_mon_tb.sv
module excl_mon_tb;
   import excl_mon_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_agent = '0;
   logic [1:0]  req_op = '0;
   logic [31:0] req_addr = '0;
   logic        mem_wr_en, stx_done, stx_fail;
   int          n_checks = 0;
   int          n_errors = 0;

   always #10 clk = ~clk;  // 50 MHz

   excl_mon u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_agent(req_agent),
      .req_op(req_op), .req_addr(req_addr),
      .mem_wr_en(mem_wr_en), .stx_done(stx_done), .stx_fail(stx_fail)
   );

   // fields: agent[2] op[2] addr[32] exp_wr exp_done exp_fail
   localparam int NV = 30;
   localparam logic [38:0] VEC [NV] = '{
      {2'd0, OP_STX,  32'h100, 3'b011},  // R1 nothing marked yet
      {2'd0, OP_LDX,  32'h100, 3'b000},  // R3
      {2'd0, OP_STX,  32'h13C, 3'b110},  // R3 same 64-byte block
      {2'd0, OP_STX,  32'h100, 3'b011},  // R6 already reopened
      {2'd0, OP_LDX,  32'h200, 3'b000},  // R5
      {2'd1, OP_LDX,  32'h210, 3'b000},  // R5 shared block
      {2'd1, OP_STX,  32'h200, 3'b110},  // R5 passes and clears agent 0
      {2'd0, OP_STX,  32'h220, 3'b011},  // R5 lost its reservation
      {2'd2, OP_LDX,  32'h400, 3'b000},  // R10
      {2'd3, OP_STX,  32'h400, 3'b011},  // R10 failing store-excl
      {2'd2, OP_STX,  32'h404, 3'b110},  // R10 survivor passes
      {2'd1, OP_LDX,  32'h600, 3'b000},  // R7
      {2'd3, OP_ST,   32'h63C, 3'b100},  // R7 plain store writes
      {2'd1, OP_STX,  32'h600, 3'b011},  // R7 reservation removed
      {2'd0, OP_LDX,  32'h700, 3'b000},  // R8
      {2'd1, OP_LDX,  32'h700, 3'b000},  // R8
      {2'd0, OP_CLRX, 32'h700, 3'b000},  // R8 no write
      {2'd1, OP_STX,  32'h700, 3'b110},  // R8 other agent untouched
      {2'd0, OP_STX,  32'h700, 3'b011},  // R8 issuer cleared
      {2'd2, OP_LDX,  32'h900, 3'b000},  // R9
      {2'd2, OP_ST,   32'h900, 3'b100},  // R9 own store
      {2'd2, OP_STX,  32'h900, 3'b110},  // R9 still reserved
      {2'd3, OP_LDX,  32'hA3F, 3'b000},  // R3 last byte of block
      {2'd3, OP_STX,  32'hA40, 3'b011},  // R3 next block fails
      {2'd0, OP_LDX,  32'hB00, 3'b000},  // R2
      {2'd1, OP_LDX,  32'hC00, 3'b000},  // R2
      {2'd0, OP_STX,  32'hB00, 3'b110},  // R2
      {2'd1, OP_STX,  32'hC00, 3'b110},  // R2
      {2'd0, OP_LDX,  32'h800, 3'b000},  // R4
      {2'd0, OP_STX,  32'h880, 3'b011}   // R4 address outside mark
   };
   localparam int VREQ [NV] = '{1,3,3,6,5,5,5,5,10,10,10,7,7,7,8,8,8,8,8,9,9,9,3,3,2,2,2,2,4,4};

   task automatic issue(input logic v, input logic [1:0] a, input logic [1:0] o,
                        input logic [31:0] ad);
      @(negedge clk);
      req_valid = v; req_agent = a; req_op = o; req_addr = ad;
      #5;
   endtask

   task automatic check(input int req, input logic [2:0] exp);
      logic [2:0] act;
      act = {mem_wr_en, stx_done, stx_fail};
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL R%0d: {wr,done,fail} actual=%b expected=%b", req, act, exp);
      end
   endtask

   initial begin
      #2000000;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #5 check(1, 3'b000);  // R1 quiet during reset
      @(negedge clk) rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         issue(1'b1, VEC[i][38:37], VEC[i][36:35], VEC[i][34:3]);
         check(VREQ[i], VEC[i][2:0]);
      end
      // R11: idle cycle with a store on the bus changes nothing
      issue(1'b1, 2'd0, OP_LDX, 32'hE00);
      issue(1'b0, 2'd1, OP_ST, 32'hE00);
      check(11, 3'b000);
      issue(1'b1, 2'd0, OP_STX, 32'hE00);
      check(11, 3'b110);
      // R1: reset drops a live reservation
      issue(1'b1, 2'd2, OP_LDX, 32'hD00);
      issue(1'b0, 2'd0, OP_LDX, 32'h0);
      rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      issue(1'b1, 2'd2, OP_STX, 32'hD00);
      check(1, 3'b011);
      issue(1'b0, 2'd0, OP_LDX, 32'h0);
      check(11, 3'b000);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule